// File: doc/BRIEF.md
# Programmable Channel Ratio Divider

This block divides a fast loop clock, taken from the oscillator that a frequency synthesizer steers, by an integer ratio chosen on a 9-bit parallel code. Once per division period it raises a single-cycle pulse, and a phase comparator uses that pulse as its divided-feedback event. To change channel, the code is changed. The new ratio applies from the start of the following period, so the current period is never cut short or stretched.

The code is plain unsigned binary with bit 0 as the least significant bit. An input that is left open reads as 0. Codes 2 to 511 divide by their own value. The two lowest codes are exceptions: 0 divides by 2 and 1 divides by 3, so every code gives a legal ratio. A small mapper turns the code into the effective ratio. A loadable down-counter holds the count through the period. A three-state controller sequences the counter.

The controller has three states. ST_ARM is the reset state. On the first edge after reset it loads the ratio and moves to ST_COUNT. ST_COUNT decrements the counter on each edge. When the counter shows 2 it moves to ST_TERM, and the counter reaches 1. ST_TERM drives the output pulse and reloads the ratio. It always returns to ST_COUNT on the next edge.

Top module: `chan_ratio_divider`

## Requirements
- R1: While rst_n is low, div_pulse is 0. A reset asserted in the middle of a period discards the count in progress, and counting restarts when reset is released.
- R2: For a ratio_code value N from 2 to 511 (unsigned binary, bit 0 least significant, 511 being all ones), div_pulse is high once every N cycles of clk_vco.
- R3: Code 0 gives a pulse period of 2 cycles.
- R4: Code 1 gives a pulse period of 3 cycles.
- R5: Each pulse on div_pulse lasts exactly one clock cycle.
- R6: ratio_code is sampled only at the rising edge that ends a pulse cycle, and at the first rising edge after reset. A change at any other time leaves the running period unchanged and sets the length of the next period.
- R7: After reset is released, the first pulse falls in the N-th cycle. Cycle 1 is the one that follows the first rising edge seen with rst_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Loop clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 9 | Division code, unsigned binary, bit 0 least significant |
| div_pulse | output | 1 | One-cycle pulse, once per division period |

## Verification
The case that is hardest to reach from the ports is a ratio change that lands in the middle of a period. The old ratio must finish its period before the new one applies. The bench reaches it by waiting for a pulse, moving a fixed number of cycles into the next period and then changing the code. It then measures the remainder of that period and the whole of the period after it. The two exception codes, the all-ones code and a reset in mid-period are also driven. A behavioural model, which tracks each period by position and length, is compared with div_pulse on every cycle.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Controller states of the ratio divider
    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_COUNT = 2'd1,
        ST_TERM  = 2'd2
    } div_state_t;

endpackage

// File: rtl/pdiv_ratio_map.sv
// Turns the raw code into the effective division ratio.
// Codes 0 and 1 are lifted to 2 and 3 by setting bit 1; all other codes pass unchanged.
module pdiv_ratio_map #(
    parameter int CODE_W = 9
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] ratio_o
);

    logic upper_zero;

    assign upper_zero = ~|code_i[CODE_W-1:1];
    assign ratio_o[0] = code_i[0];
    assign ratio_o[1] = code_i[1] | upper_zero;

    generate
        for (genvar b = 2; b < CODE_W; b++) begin : g_pass
            assign ratio_o[b] = code_i[b];
        end
    endgenerate

endmodule

// File: rtl/pdiv_count_path.sv
// Loadable down-counter that holds the position within the current period.
module pdiv_count_path #(
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              dec_i,
    input  logic [CODE_W-1:0] load_val_i,
    output logic              at_two_o
);

    localparam logic [CODE_W-1:0] CNT_TWO = CODE_W'(2);

    logic [CODE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_two_o = (cnt_q == CNT_TWO);

    // R6: the value taken at a reload is the ratio presented on that edge
    p_reload_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) && $past(rst_n) |-> cnt_q == $past(load_val_i));

    // R2: a decrement never starts below 2, so the count cannot wrap
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> cnt_q > CODE_W'(1));

endmodule

// File: rtl/pdiv_ctrl_fsm.sv
// Sequences arming, counting and the terminal (pulse) cycle.
module pdiv_ctrl_fsm
    import pdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic at_two_i,
    output logic load_o,
    output logic dec_o,
    output logic pulse_o
);

    div_state_t state_q;
    div_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:   state_d = ST_COUNT;
            ST_COUNT: state_d = at_two_i ? ST_TERM : ST_COUNT;
            ST_TERM:  state_d = ST_COUNT;
            default:  state_d = ST_ARM;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        dec_o   = 1'b0;
        pulse_o = 1'b0;
        unique case (state_q)
            ST_ARM:   load_o = 1'b1;
            ST_COUNT: dec_o  = 1'b1;
            ST_TERM: begin
                load_o  = 1'b1;
                pulse_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: the terminal state lasts one cycle and hands back to counting
    p_term_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TERM |=> state_q == ST_COUNT);

    // R1: the controller never returns to arming while out of reset
    p_no_rearm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_ARM |=> state_q != ST_ARM);

endmodule

// File: rtl/chan_ratio_divider.sv
// Programmable divide-by-N counter for a synthesizer feedback path.
module chan_ratio_divider #(
    parameter int CODE_W = 9
) (
    input  logic              clk_vco,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              div_pulse
);

    logic [CODE_W-1:0] ratio_eff;
    logic              load_en;
    logic              dec_en;
    logic              at_two;

    pdiv_ratio_map #(.CODE_W(CODE_W)) u_map (
        .code_i  (ratio_code),
        .ratio_o (ratio_eff)
    );

    pdiv_count_path #(.CODE_W(CODE_W)) u_cnt (
        .clk        (clk_vco),
        .rst_n      (rst_n),
        .load_i     (load_en),
        .dec_i      (dec_en),
        .load_val_i (ratio_eff),
        .at_two_o   (at_two)
    );

    pdiv_ctrl_fsm u_fsm (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .at_two_i (at_two),
        .load_o   (load_en),
        .dec_o    (dec_en),
        .pulse_o  (div_pulse)
    );

    // R3/R4: every code maps to a ratio of at least 2
    p_ratio_floor_r3: assert property (@(posedge clk_vco) disable iff (!rst_n)
        ratio_eff >= CODE_W'(2));

    // R4: the mapping keeps parity, so code 1 yields an odd ratio
    p_ratio_parity_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
        ratio_eff[0] == ratio_code[0]);

    // R5: a pulse is never followed directly by another pulse
    p_pulse_narrow_r5: assert property (@(posedge clk_vco) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

endmodule

// File: tb/chan_ratio_divider_test.sv
`timescale 1ns/1ps
module chan_ratio_divider_test;

    logic       clk_vco = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] ratio_code = 9'd0;
    logic       div_pulse;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_tag = "R1";

    chan_ratio_divider uut (
        .clk_vco    (clk_vco),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .div_pulse  (div_pulse)
    );

    always #2.5 clk_vco = ~clk_vco;

    // Behavioural reference: position within the period and the period length
    bit m_started = 1'b0;
    int m_pos = 0;
    int m_per = 0;
    bit m_exp = 1'b0;

    function automatic int eff_of(logic [8:0] c);
        if (c < 9'd2) return int'(c) + 2;
        return int'(c);
    endfunction

    always @(posedge clk_vco) begin
        if (!rst_n) begin
            m_started = 1'b0;
            m_pos = 0;
            m_per = 0;
        end else if (!m_started) begin
            m_started = 1'b1;
            m_per = eff_of(ratio_code);
            m_pos = 1;
        end else if (m_pos == m_per) begin
            m_per = eff_of(ratio_code);
            m_pos = 1;
        end else begin
            m_pos++;
        end
        m_exp = m_started && (m_pos == m_per);
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk_vco) begin
        check(cur_tag, int'(div_pulse), int'(m_exp));
    end

    // Watchdog
    always @(posedge clk_vco) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Length of the next complete period, from one pulse to the following one
    task automatic gap(string tag, int expn);
        int k;
        @(negedge clk_vco);
        while (!div_pulse) @(negedge clk_vco);
        k = 0;
        do begin
            @(negedge clk_vco);
            k++;
            if (k == 1) check("R5", int'(div_pulse), 0);
        end while (!div_pulse && k < 2000);
        check(tag, k, expn);
    endtask

    // Cycles from reset release to the first pulse
    task automatic first_pulse(string tag, int expn);
        int k;
        k = 0;
        rst_n = 1'b1;
        do begin
            @(negedge clk_vco);
            k++;
        end while (!div_pulse && k < 2000);
        check(tag, k, expn);
    endtask

    initial begin
        int k;
        cur_tag = "R1";
        ratio_code = 9'd5;
        repeat (4) @(negedge clk_vco);
        check("R1", int'(div_pulse), 0);

        cur_tag = "R7";
        first_pulse("R7", 5);

        cur_tag = "R2";
        ratio_code = 9'd4;   gap("R2", 4);
        ratio_code = 9'd7;   gap("R2", 7);
        ratio_code = 9'd300; gap("R2", 300);
        ratio_code = 9'd255; gap("R2", 255);
        ratio_code = 9'd511; gap("R2", 511);
        ratio_code = 9'd2;   gap("R2", 2);

        cur_tag = "R3";
        ratio_code = 9'd0;   gap("R3", 2);
        gap("R3", 2);

        cur_tag = "R4";
        ratio_code = 9'd1;   gap("R4", 3);
        gap("R4", 3);

        // R6: change the code three cycles into a period of 10
        cur_tag = "R6";
        ratio_code = 9'd10;
        gap("R6", 10);
        repeat (3) @(negedge clk_vco);
        ratio_code = 9'd20;
        k = 3;
        while (!div_pulse && k < 2000) begin
            @(negedge clk_vco);
            k++;
        end
        check("R6", k, 10);
        k = 0;
        do begin
            @(negedge clk_vco);
            k++;
        end while (!div_pulse && k < 2000);
        check("R6", k, 20);

        // R1: reset in mid-period, then restart with a new code
        cur_tag = "R1";
        ratio_code = 9'd6;
        gap("R1", 6);
        repeat (2) @(negedge clk_vco);
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk_vco);
            check("R1", int'(div_pulse), 0);
        end
        ratio_code = 9'd9;
        cur_tag = "R7";
        first_pulse("R7", 9);
        gap("R7", 9);

        repeat (5) @(negedge clk_vco);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule